// File: doc/BRIEF.md
# Decimal-Capable Binary Adder Stage

This block is the adder stage of an 8-bit processor datapath. It adds two operands and a carry-in, or subtracts by adding the bitwise complement of the second operand. In decimal add mode each 4-bit digit forces its carry out high whenever its binary sum goes above 9. That forced carry feeds the next digit up, so the carry out of the top digit is a true decimal carry for legal BCD operands.

The block hands out the raw, uncorrected digit sums together with the carries a later stage needs. These are the carry out of the low digit (half carry), the final carry, the carry into the most significant bit, and overflow. A downstream stage applies the +6 or +10 digit correction. When the decimal flag is set during a subtraction, the flag is ignored and the block does a plain binary add of the complemented operand.

Results are captured on a clock edge when the input strobe is high. A matching output strobe follows one cycle later.

Top module: `bcd_adder_core`

## Requirements
- R1: With dec_mode=0 and sub_sel=0, {carry_out, sum_raw} equals op_a + op_b + carry_in. half_carry is the binary carry out of bit 3.
- R2: With sub_sel=1, {carry_out, sum_raw} equals op_a + ~op_b + carry_in, and half_carry is the binary carry out of bit 3. This holds for either value of dec_mode, so carries are inverted borrows.
- R3: With dec_mode=1 and sub_sel=0, let L be op_a[3:0] + op_b[3:0] + carry_in. half_carry is 1 exactly when L > 9, and sum_raw[3:0] equals L mod 16.
- R4: With dec_mode=1 and sub_sel=0, let U be op_a[7:4] + op_b[7:4] + half_carry. carry_out is 1 exactly when U > 9, and sum_raw[7:4] equals U mod 16.
- R5: In every mode, overflow equals carry6 XOR carry_out. In binary add this matches signed two's-complement overflow of the raw sum.
- R6: carry6 is the carry into bit 7, which is the carry out of the sum of bits 6..4 of both operands plus the carry entering bit 4.
- R7: No digit correction is applied. For example, a decimal add of 0x09 and 0x01 yields sum_raw 0x1A with half_carry 1.
- R8: Non-BCD digits in decimal add follow the greater-than-9 rule with no other handling. For example, 0x0F + 0x00 gives sum_raw 0x1F, half_carry 1 and carry_out 0.
- R9: Outputs update one clock after an edge at which in_valid is 1, and out_valid is 1 in that cycle. After an edge with in_valid 0, out_valid is 0 and the data outputs keep their previous values.
- R10: A synchronous reset clears out_valid and every data output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the operands |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand (complemented when subtracting) |
| carry_in | input | 1 | Carry into bit 0 |
| dec_mode | input | 1 | Decimal digit carries; acts only when adding |
| sub_sel | input | 1 | 1 selects subtract |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| sum_raw | output | 8 | Uncorrected sum |
| half_carry | output | 1 | Carry out of bit 3 |
| carry_out | output | 1 | Carry out of bit 7 |
| overflow | output | 1 | carry6 XOR carry_out |
| carry6 | output | 1 | Carry into bit 7 |

## Verification
The forced carry out of the low digit and the forced carry out of the high digit can occur in the same decimal addition. When that happens, the first forced carry is what pushes the second digit past 9. Operands such as 0x99 + 0x01 and 0x49 + 0x51, plus a large randomized set in decimal add mode, provoke this case. Each result is compared every clock against a behavioural digit-by-digit model in the bench, which also predicts overflow and carry6 for that same cycle, when they are driven by the forced carry.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;

  typedef struct packed {
    logic [DIGIT_W-1:0] sum;
    logic               carry;
    logic               carry_msb;
  } digit_res_t;

  function automatic digit_res_t digit_add(
    input logic [DIGIT_W-1:0] a,
    input logic [DIGIT_W-1:0] b,
    input logic               cin,
    input logic               dec_en
  );
    digit_res_t          r;
    logic [DIGIT_W:0]    full;
    logic [DIGIT_W-1:0]  part;
    full = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    part = {1'b0, a[DIGIT_W-2:0]} + {1'b0, b[DIGIT_W-2:0]}
         + {{(DIGIT_W-1){1'b0}}, cin};
    r.sum       = full[DIGIT_W-1:0];
    r.carry_msb = part[DIGIT_W-1];
    if (dec_en)
      r.carry = (full > (DIGIT_W+1)'(DIGIT_MAX));
    else
      r.carry = full[DIGIT_W];
    return r;
  endfunction

endpackage

// File: rtl/bcd_operand_prep.sv
module bcd_operand_prep #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_b,
  input  logic              dec_mode,
  input  logic              sub_sel,
  output logic [DATA_W-1:0] b_eff,
  output logic              dec_active
);
  always_comb begin
    b_eff      = sub_sel ? ~op_b : op_b;
    dec_active = dec_mode & ~sub_sel;
  end
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  logic               cin,
  input  logic               dec_en,
  output logic [DIGIT_W-1:0] sum_dig,
  output logic               cout,
  output logic               cout_msb
);
  digit_res_t res;
  always_comb begin
    res      = digit_add(a_dig, b_dig, cin, dec_en);
    sum_dig  = res.sum;
    cout     = res.carry;
    cout_msb = res.carry_msb;
  end
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit #(
  parameter int NDIG = 2
) (
  input  logic [NDIG:0]   carry_chain,
  input  logic [NDIG-1:0] msb_carry,
  output logic            ac,
  output logic            c,
  output logic            c_msb,
  output logic            v
);
  always_comb begin
    ac    = carry_chain[1];
    c     = carry_chain[NDIG];
    c_msb = msb_carry[NDIG-1];
    v     = c_msb ^ c;
  end
endmodule

// File: rtl/bcd_result_reg.sv
module bcd_result_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/bcd_adder_core.sv
module bcd_adder_core
  import bcd_add_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              carry_in,
  input  logic              dec_mode,
  input  logic              sub_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum_raw,
  output logic              half_carry,
  output logic              carry_out,
  output logic              overflow,
  output logic              carry6
);
  localparam int NDIG  = DATA_W / DIGIT_W;
  localparam int PACKW = DATA_W + 4;

  logic [DATA_W-1:0] b_eff;
  logic              dec_active;
  logic [NDIG:0]     carry_chain;
  logic [NDIG-1:0]   msb_carry;
  logic [NDIG-1:0]   digit_carry;
  logic [DATA_W-1:0] sum_comb;
  logic              ac_comb, c_comb, c6_comb, v_comb;
  logic [PACKW-1:0]  pack_d, pack_q;

  bcd_operand_prep #(.DATA_W(DATA_W)) prep_i (
    .op_b       (op_b),
    .dec_mode   (dec_mode),
    .sub_sel    (sub_sel),
    .b_eff      (b_eff),
    .dec_active (dec_active)
  );

  assign carry_chain[0] = carry_in;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    bcd_digit_stage dig_i (
      .a_dig    (op_a [g*DIGIT_W +: DIGIT_W]),
      .b_dig    (b_eff[g*DIGIT_W +: DIGIT_W]),
      .cin      (carry_chain[g]),
      .dec_en   (dec_active),
      .sum_dig  (sum_comb[g*DIGIT_W +: DIGIT_W]),
      .cout     (carry_chain[g+1]),
      .cout_msb (msb_carry[g])
    );
  end

  assign digit_carry = carry_chain[NDIG:1];

  bcd_flag_unit #(.NDIG(NDIG)) flag_i (
    .carry_chain (carry_chain),
    .msb_carry   (msb_carry),
    .ac          (ac_comb),
    .c           (c_comb),
    .c_msb       (c6_comb),
    .v           (v_comb)
  );

  assign pack_d = {sum_comb, ac_comb, c_comb, v_comb, c6_comb};

  bcd_result_reg #(.W(PACKW)) reg_i (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (pack_d),
    .q_valid (out_valid),
    .q       (pack_q)
  );

  assign sum_raw    = pack_q[PACKW-1:4];
  assign half_carry = pack_q[3];
  assign carry_out  = pack_q[2];
  assign overflow   = pack_q[1];
  assign carry6     = pack_q[0];

endmodule

// File: rtl/bcd_adder_core_chk.sv
module bcd_adder_core_chk #(
  parameter int DATA_W = 8,
  parameter int NDIG   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              carry_in,
  input logic              dec_mode,
  input logic              sub_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] sum_raw,
  input logic              half_carry,
  input logic              carry_out,
  input logic              overflow,
  input logic              carry6,
  input logic              dec_active,
  input logic [NDIG-1:0]   digit_carry
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] add_ref, sub_ref;
  logic [4:0]      low_ref, top_ref;
  logic            signed_ovf_ref;

  always_comb begin
    add_ref = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};
    sub_ref = {1'b0, op_a} + {1'b0, ~op_b} + {{DATA_W{1'b0}}, carry_in};
    low_ref = {1'b0, op_a[3:0]} + {1'b0, op_b[3:0]} + {4'b0, carry_in};
    top_ref = {1'b0, op_a[MSB -: 4]} + {1'b0, op_b[MSB -: 4]}
            + {4'b0, (NDIG > 1) ? digit_carry[NDIG-2] : carry_in};
    signed_ovf_ref = (op_a[MSB] == op_b[MSB]) && (add_ref[MSB] != op_a[MSB]);
  end

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && sum_raw == '0 && !half_carry && !carry_out
             && !overflow && !carry6));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(sum_raw) && $stable(carry_out)
                   && $stable(half_carry) && $stable(overflow)));

  a_r1_binary_add: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_sel && !dec_mode) |=> ({carry_out, sum_raw} == $past(add_ref)));

  a_r2_sub_binary: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_sel) |=> ({carry_out, sum_raw} == $past(sub_ref)));

  a_r2_dec_gated: assert property (@(posedge clk) disable iff (rst)
    sub_sel |-> !dec_active);

  a_r3_dec_half: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_mode && !sub_sel) |=>
      (half_carry == $past(low_ref > 5'd9) && sum_raw[3:0] == $past(low_ref[3:0])));

  a_r4_dec_top: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_mode && !sub_sel) |=> (carry_out == $past(top_ref > 5'd9)));

  a_r5_signed_ovf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_sel && !dec_mode) |=> (overflow == $past(signed_ovf_ref)));

endmodule

bind bcd_adder_core bcd_adder_core_chk #(.DATA_W(DATA_W), .NDIG(NDIG)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op_a        (op_a),
  .op_b        (op_b),
  .carry_in    (carry_in),
  .dec_mode    (dec_mode),
  .sub_sel     (sub_sel),
  .out_valid   (out_valid),
  .sum_raw     (sum_raw),
  .half_carry  (half_carry),
  .carry_out   (carry_out),
  .overflow    (overflow),
  .carry6      (carry6),
  .dec_active  (dec_active),
  .digit_carry (digit_carry)
);

// File: tb/bcd_adder_core_tb_top.sv
`timescale 1ns/1ps
module bcd_adder_core_tb_top;

  logic       clk = 1'b0;
  logic       rst, in_valid, carry_in, dec_mode, sub_sel;
  logic [7:0] op_a, op_b;
  logic       out_valid, half_carry, carry_out, overflow, carry6;
  logic [7:0] sum_raw;

  int checks = 0;
  int errors = 0;
  bit [12:0] exp_q[$];
  bit [11:0] held = '0;

  always #2.5 clk = ~clk;

  bcd_adder_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .dec_mode(dec_mode), .sub_sel(sub_sel),
    .out_valid(out_valid), .sum_raw(sum_raw), .half_carry(half_carry),
    .carry_out(carry_out), .overflow(overflow), .carry6(carry6)
  );

  // Behavioural model: {valid, sum[7:0], ac, c, v, c6}
  function automatic bit [12:0] model(bit [7:0] a, bit [7:0] b, bit ci, bit d, bit s);
    int bi, lo, hi, mid, sum;
    bit dadd, ac, c, c6;
    bi   = s ? (255 - int'(b)) : int'(b);
    dadd = d && !s;
    lo   = (int'(a) % 16) + (bi % 16) + int'(ci);
    ac   = dadd ? (lo > 9) : (lo > 15);
    hi   = (int'(a) / 16) + (bi / 16) + int'(ac);
    c    = dadd ? (hi > 9) : (hi > 15);
    mid  = ((int'(a) / 16) % 8) + ((bi / 16) % 8) + int'(ac);
    c6   = (mid > 7);
    sum  = (hi % 16) * 16 + (lo % 16);
    return {1'b1, 8'(sum), ac, c, c ^ c6, c6};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit [7:0] a, bit [7:0] b, bit ci, bit d, bit s, string tag);
    bit [12:0] e;
    in_valid = v; op_a = a; op_b = b; carry_in = ci; dec_mode = d; sub_sel = s;
    if (v) begin
      e = model(a, b, ci, d, s);
      held = e[11:0];
    end else begin
      e = {1'b0, held};
    end
    exp_q.push_back(e);
    @(negedge clk);
    e = exp_q.pop_front();
    chk("R9 out_valid", int'(out_valid), int'(e[12]));
    chk({tag, " sum_raw"}, int'(sum_raw), int'(e[11:4]));
    chk({(d && !s) ? "R3" : tag, " half_carry"}, int'(half_carry), int'(e[3]));
    chk({(d && !s) ? "R4" : tag, " carry_out"}, int'(carry_out), int'(e[2]));
    chk("R5 overflow", int'(overflow), int'(e[1]));
    chk("R6 carry6", int'(carry6), int'(e[0]));
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b1; op_a = 8'hFF; op_b = 8'hFF; carry_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 outputs", int'({sum_raw, half_carry, carry_out, overflow, carry6}), 0);
    rst = 1'b0;
    held = '0;
    exp_q.delete();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst = 1'b1; in_valid = 0; op_a = 0; op_b = 0; carry_in = 0; dec_mode = 0; sub_sel = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", int'(out_valid), 0);
    chk("R10 reset sum", int'(sum_raw), 0);
    rst = 1'b0;

    // R1 binary add corner: 0x7F + 0x01 -> 0x80, signed overflow
    step(1, 8'h7F, 8'h01, 0, 0, 0, "R1");
    chk("R1 literal sum", int'(sum_raw), 'h80);
    chk("R5 literal overflow", int'(overflow), 1);
    // R2 subtract with decimal flag ignored: 0x00 - 0x01 -> 0xFF borrow
    step(1, 8'h00, 8'h01, 1, 1, 1, "R2");
    chk("R2 literal sum", int'(sum_raw), 'hFF);
    chk("R2 literal carry", int'(carry_out), 0);
    // R7 no correction: 0x09 + 0x01 decimal -> 0x1A
    step(1, 8'h09, 8'h01, 0, 1, 0, "R7");
    chk("R7 literal sum", int'(sum_raw), 'h1A);
    chk("R3 literal half_carry", int'(half_carry), 1);
    // Both digit carries forced: 0x99 + 0x01 -> raw 0xAA, C=1
    step(1, 8'h99, 8'h01, 0, 1, 0, "R4");
    chk("R4 literal sum", int'(sum_raw), 'hAA);
    chk("R4 literal carry", int'(carry_out), 1);
    step(1, 8'h49, 8'h51, 0, 1, 0, "R4");
    chk("R4 literal carry 49+51", int'(carry_out), 1);
    // R8 illegal digit
    step(1, 8'h0F, 8'h00, 0, 1, 0, "R8");
    chk("R8 literal sum", int'(sum_raw), 'h1F);
    chk("R8 literal carry", int'(carry_out), 0);
    // R9 hold while idle
    step(0, 8'h12, 8'h34, 1, 0, 0, "R9");
    step(0, 8'hAB, 8'hCD, 0, 1, 1, "R9");
    chk("R9 held sum", int'(sum_raw), 'h1F);

    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 1500; k++) begin
        bit d = m[0];
        bit s = m[1];
        bit [7:0] a = 8'($urandom);
        bit [7:0] b = 8'($urandom);
        if (d && !s && k % 2 == 0) begin
          a = 8'({4'($urandom % 10), 4'($urandom % 10)});
          b = 8'({4'($urandom % 10), 4'($urandom % 10)});
        end
        step(($urandom % 5) != 0, a, b, 1'($urandom), d, s, s ? "R2" : (d ? "R3" : "R1"));
      end
    end

    do_reset();
    step(1, 8'h55, 8'h55, 1, 1, 0, "R4");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule